// File: doc/BRIEF.md
# ECP Port Interrupt and DMA Gate Control

This block holds the low control bits of an extended-mode parallel port and turns FIFO state, DMA progress and the peripheral fault line into one host interrupt pulse and one DMA-enable level. A host writes three control bits through a register strobe and reads back those bits together with two read-only FIFO status flags. The FIFO, the handshake engine and the DMA engine live elsewhere. Their occupancy counts, the port direction and a terminal-count pulse arrive as inputs.

A service interrupt masks itself. When its condition holds and the hold bit is clear, hardware sets the hold bit and raises one pulse. Software must then clear the hold bit before another service interrupt or any DMA can happen. The condition depends on the mode:
- With DMA armed, the condition is terminal count.
- Otherwise, in forward direction, it is enough free space.
- Otherwise, in reverse direction, it is enough valid data.

A falling edge on the synchronised fault line gives a separate interrupt. Clearing the fault mask while the fault is already active also raises an interrupt, so a fault that appears between a register read and the following write is not lost.

Top module: `ecp_ctrl_irq`

## Requirements
- R1: After reset the readback word is bit0 faultMask=0, bit1 dmaArm=0, bit2 svcHold=1, bit3 fifoFull, bit4 fifoEmpty. In the same state `irqPulse` and `dmaEnable` are 0.
- R2: With faultMask=0, a high-to-low transition of `faultN` gives exactly one `irqPulse` within five cycles. With faultMask=1 it gives none.
- R3: A write that takes faultMask from 1 to 0 while `faultN` is low gives exactly one `irqPulse`. The same write while `faultN` is high gives none.
- R4: `dmaEnable` is 1 exactly when dmaArm=1 and svcHold=0.
- R5: With dmaArm=0, dirRev=0 and svcHold=0, a service interrupt fires exactly when freeCount >= wrThresh.
- R6: With dmaArm=0, dirRev=1 and svcHold=0, a service interrupt fires exactly when validCount >= rdThresh.
- R7: With dmaArm=1 and svcHold=0, a `dmaTc` pulse fires a service interrupt. Threshold conditions have no effect in this mode.
- R8: When a service interrupt fires, svcHold reads 1 and exactly one `irqPulse` is produced. No further service interrupt occurs until svcHold is written to 0. Writing svcHold to 1 produces no interrupt.
- R9: fifoFull (bit3) reads 1 exactly when freeCount is 0. fifoEmpty (bit4) reads 1 exactly when validCount is 0. Writes to bits 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 5 | Write data, only bits 0..2 are stored |
| regRdData | output | 5 | Readback: control bits and FIFO flags |
| faultN | input | 1 | Asynchronous active-low peripheral fault |
| dirRev | input | 1 | Port direction, 1 = reverse |
| freeCount | input | CW | Free FIFO entries |
| validCount | input | CW | Valid FIFO entries |
| wrThresh | input | CW | Forward service threshold |
| rdThresh | input | CW | Reverse service threshold |
| dmaTc | input | 1 | DMA terminal-count pulse |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| dmaEnable | output | 1 | DMA request permission |

## Verification
The checker assumes that the occupancy inputs describe one FIFO: freeCount plus validCount always equals the depth, so full and empty can never be reported together. The bench keeps to this by always deriving freeCount as depth minus validCount. The hold-bit properties assume that the host does not write svcHold to 0 in the same cycle a service condition fires. The bench does not write in that cycle, because it changes counts, thresholds and direction only while svcHold is 1. It waits several cycles between a stimulus and the next write, so separate interrupt sources never overlap.

// File: rtl/ecp_ctrl_pkg.sv
package ecp_ctrl_pkg;
  // register bit positions
  localparam int BIT_FMASK = 0;
  localparam int BIT_DARM  = 1;
  localparam int BIT_HOLD  = 2;
  localparam int BIT_FULL  = 3;
  localparam int BIT_EMPTY = 4;
  localparam int REG_W     = 5;

  // datapath -> control observations
  typedef struct packed {
    logic faultLow;
    logic faultFell;
    logic svcCond;
  } dpStatus_t;

  // control -> datapath strobes
  typedef struct packed {
    logic faultIrq;
    logic svcIrq;
  } irqStrobe_t;
endpackage

// File: rtl/ecp_ctrl_dp.sv
module ecp_ctrl_dp
  import ecp_ctrl_pkg::*;
#(
  parameter int CW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          faultN,
  input  logic          dirRev,
  input  logic          dmaArm,
  input  logic [CW-1:0] freeCount,
  input  logic [CW-1:0] validCount,
  input  logic [CW-1:0] wrThresh,
  input  logic [CW-1:0] rdThresh,
  input  logic          dmaTc,
  input  irqStrobe_t    strobe,
  output dpStatus_t     status,
  output logic          fifoFull,
  output logic          fifoEmpty,
  output logic          irqPulse
);
  // syncQ[0..SYNC_STAGES-1] synchronise, last flop keeps previous value
  logic [SYNC_STAGES:0] syncQ;
  logic faultSync;
  logic faultPrev;
  logic fwdHit;
  logic revHit;
  logic modeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], faultN};
  end

  assign faultSync = syncQ[SYNC_STAGES-1];
  assign faultPrev = syncQ[SYNC_STAGES];

  assign fwdHit = (freeCount >= wrThresh);
  assign revHit = (validCount >= rdThresh);

  generate
    if (CW > 0) begin : g_mode
      always_comb begin
        if (dmaArm)      modeHit = dmaTc;
        else if (dirRev) modeHit = revHit;
        else             modeHit = fwdHit;
      end
    end
  endgenerate

  always_comb begin
    status.faultLow  = ~faultSync;
    status.faultFell = faultPrev & ~faultSync;
    status.svcCond   = modeHit;
  end

  assign fifoFull  = (freeCount == '0);
  assign fifoEmpty = (validCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPulse <= 1'b0;
    else       irqPulse <= strobe.faultIrq | strobe.svcIrq;
  end
endmodule

// File: rtl/ecp_ctrl_ctl.sv
module ecp_ctrl_ctl
  import ecp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  input  dpStatus_t        status,
  output irqStrobe_t       strobe,
  output logic             faultMask,
  output logic             dmaArm,
  output logic             svcHold,
  output logic             dmaEnable
);
  logic maskDrop;
  logic faultEv;
  logic svcEv;

  // clearing the mask while the fault is low must not lose the event
  assign maskDrop = regWr & faultMask & ~regWrData[BIT_FMASK];
  assign faultEv  = (~faultMask & status.faultFell) | (maskDrop & status.faultLow);
  assign svcEv    = ~svcHold & status.svcCond;

  always_comb begin
    strobe.faultIrq = faultEv;
    strobe.svcIrq   = svcEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultMask <= 1'b0;
      dmaArm    <= 1'b0;
    end else if (regWr) begin
      faultMask <= regWrData[BIT_FMASK];
      dmaArm    <= regWrData[BIT_DARM];
    end
  end

  // hardware set has priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      svcHold <= 1'b1;
    else if (svcEv) svcHold <= 1'b1;
    else if (regWr) svcHold <= regWrData[BIT_HOLD];
  end

  assign dmaEnable = dmaArm & ~svcHold;
endmodule

// File: rtl/ecp_ctrl_irq.sv
module ecp_ctrl_irq
  import ecp_ctrl_pkg::*;
#(
  parameter  int DEPTH       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int CW          = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             faultN,
  input  logic             dirRev,
  input  logic [CW-1:0]    freeCount,
  input  logic [CW-1:0]    validCount,
  input  logic [CW-1:0]    wrThresh,
  input  logic [CW-1:0]    rdThresh,
  input  logic             dmaTc,
  output logic             irqPulse,
  output logic             dmaEnable
);
  dpStatus_t  status;
  irqStrobe_t strobe;
  logic faultMask;
  logic dmaArm;
  logic svcHold;
  logic fifoFull;
  logic fifoEmpty;

  ecp_ctrl_dp #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .faultN(faultN), .dirRev(dirRev), .dmaArm(dmaArm),
    .freeCount(freeCount), .validCount(validCount), .wrThresh(wrThresh),
    .rdThresh(rdThresh), .dmaTc(dmaTc), .strobe(strobe), .status(status),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .irqPulse(irqPulse)
  );

  ecp_ctrl_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
    .status(status), .strobe(strobe), .faultMask(faultMask), .dmaArm(dmaArm),
    .svcHold(svcHold), .dmaEnable(dmaEnable)
  );

  always_comb begin
    regRdData            = '0;
    regRdData[BIT_FMASK] = faultMask;
    regRdData[BIT_DARM]  = dmaArm;
    regRdData[BIT_HOLD]  = svcHold;
    regRdData[BIT_FULL]  = fifoFull;
    regRdData[BIT_EMPTY] = fifoEmpty;
  end
endmodule

// File: rtl/ecp_ctrl_irq_chk.sv
module ecp_ctrl_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWr,
  input logic [4:0]    regWrData,
  input logic [4:0]    regRdData,
  input logic [CW-1:0] freeCount,
  input logic [CW-1:0] validCount,
  input logic          irqPulse,
  input logic          dmaEnable
);
  a_r4_hold_blocks_dma: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[2] |-> !dmaEnable);

  a_r8_hw_set_pulses: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(regRdData[2]) && !$past(regWr && regWrData[2])) |-> irqPulse);

  a_r8_hold_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[2] && !(regWr && !regWrData[2])) |=> regRdData[2]);

  a_r9_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdData[3] && regRdData[4]));

  a_r4_arm_needed: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[1] |-> !dmaEnable);
endmodule

bind ecp_ctrl_irq ecp_ctrl_irq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
  .regRdData(regRdData), .freeCount(freeCount), .validCount(validCount),
  .irqPulse(irqPulse), .dmaEnable(dmaEnable)
);

// File: tb/ecp_ctrl_irq_bench.sv
module ecp_ctrl_irq_bench;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [4:0]    regWrData = '0;
  logic [4:0]    regRdData;
  logic          faultN = 1'b1;
  logic          dirRev = 1'b0;
  logic [CW-1:0] freeCount = CW'(DEPTH);
  logic [CW-1:0] validCount = '0;
  logic [CW-1:0] wrThresh = CW'(DEPTH);
  logic [CW-1:0] rdThresh = CW'(DEPTH);
  logic          dmaTc = 1'b0;
  logic          irqPulse;
  logic          dmaEnable;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecp_ctrl_irq #(.DEPTH(DEPTH)) u_ecp_ctrl_irq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .faultN(faultN), .dirRev(dirRev),
    .freeCount(freeCount), .validCount(validCount), .wrThresh(wrThresh),
    .rdThresh(rdThresh), .dmaTc(dmaTc), .irqPulse(irqPulse), .dmaEnable(dmaEnable)
  );

  always @(negedge clk) if (irqPulse) pulses++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] d);
    @(negedge clk);
    regWr = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
    regWrData = '0;
  endtask

  task automatic wrCtl(input bit m, input bit a, input bit h);
    wrReg({2'b00, h, a, m});
  endtask

  task automatic setValid(input int v);
    validCount = CW'(v);
    freeCount  = CW'(DEPTH - v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state, FIFO empty
    check("R1 readback", int'(regRdData), 5'b10100);
    check("R1 irq", int'(irqPulse), 0);
    check("R1 dma", int'(dmaEnable), 0);

    // R9 full/empty sweep, plus ignored writes to bits 3,4
    for (int v = 0; v <= DEPTH; v++) begin
      @(negedge clk);
      setValid(v);
      #1;
      check("R9 full", int'(regRdData[3]), (v == DEPTH) ? 1 : 0);
      check("R9 empty", int'(regRdData[4]), (v == 0) ? 1 : 0);
    end
    setValid(DEPTH / 2);
    wrReg(5'b11100);
    #1;
    check("R9 ro bits", int'(regRdData[4:3]), 0);

    // R2 fault edge, unmasked
    base = pulses;
    @(negedge clk) faultN = 1'b0;
    idle(5);
    check("R2 edge unmasked", pulses - base, 1);
    faultN = 1'b1;
    idle(4);
    // R2 masked edge
    wrCtl(1, 0, 1);
    base = pulses;
    @(negedge clk) faultN = 1'b0;
    idle(5);
    check("R2 edge masked", pulses - base, 0);
    // R3 race: clear mask while fault low
    base = pulses;
    wrCtl(0, 0, 1);
    idle(3);
    check("R3 unmask while low", pulses - base, 1);
    faultN = 1'b1;
    idle(4);
    wrCtl(1, 0, 1);
    base = pulses;
    wrCtl(0, 0, 1);
    idle(3);
    check("R3 unmask while high", pulses - base, 0);

    // R5 / R6 threshold sweeps in both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int thr = 1; thr <= DEPTH; thr++) begin
        for (int c = 0; c <= DEPTH; c++) begin
          bit exp;
          @(negedge clk);
          dirRev = dir[0];
          wrThresh = CW'(thr);
          rdThresh = CW'(thr);
          if (dir == 0) setValid(DEPTH - c); else setValid(c);
          exp = (c >= thr);
          base = pulses;
          wrCtl(0, 0, 0);
          idle(3);
          if (dir == 0) check("R5 fwd threshold", pulses - base, int'(exp));
          else          check("R6 rev threshold", pulses - base, int'(exp));
          check("R8 hold set", int'(regRdData[2]), int'(exp));
          wrCtl(0, 0, 1);
        end
      end
    end

    // R8 persistent condition fires once; writing hold=1 is quiet
    dirRev = 1'b0; wrThresh = 1; setValid(0);
    base = pulses;
    wrCtl(0, 0, 0);
    idle(8);
    check("R8 once per enable", pulses - base, 1);
    base = pulses;
    wrCtl(0, 0, 1);
    idle(4);
    check("R8 write one quiet", pulses - base, 0);

    // R4 / R7 DMA mode, thresholds satisfied but ignored
    wrCtl(0, 1, 1);
    #1 check("R4 held", int'(dmaEnable), 0);
    base = pulses;
    wrCtl(0, 1, 0);
    idle(4);
    check("R4 armed", int'(dmaEnable), 1);
    check("R7 threshold ignored", pulses - base, 0);
    @(negedge clk) dmaTc = 1'b1;
    @(negedge clk) dmaTc = 1'b0;
    idle(3);
    check("R7 tc fires", pulses - base, 1);
    check("R8 tc sets hold", int'(regRdData[2]), 1);
    check("R4 dma off after tc", int'(dmaEnable), 0);
    base = pulses;
    @(negedge clk) dmaTc = 1'b1;
    @(negedge clk) dmaTc = 1'b0;
    idle(3);
    check("R8 masked tc", pulses - base, 0);
    wrCtl(0, 0, 0);
    #1 check("R4 unarmed", int'(dmaEnable), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule